// File: doc/BRIEF.md
# Multi-Port Suspend Handshake Sequencer

This block coordinates system entry into a sleep state across several downstream link ports. Software asks for a sleep state by writing a request that names the target depth (S3, S4 or S5). The block then waits until the completion for that write has gone back to the requester. Only then does it tell every live port to put a turn-off message on its link. It does this without regard to the link's current power state.

Each port then reports two events as single-cycle strobes: the acknowledge of the turn-off and the link partner's request to enter the ready-for-power-removal state. A port counts as ready only when the request arrives after the acknowledge. Ports that are disabled or have no link count as ready from the start. When every port is ready, the block holds a proceed request to the power controller until that controller acknowledges entry.

If the ports do not all become ready within a set number of cycles, the block flags the stragglers and waits until software aborts. A rising edge on the resume-well wake input raises a one-cycle wake request toward the power controller and puts the sequencer back to idle. The wake is not recorded anywhere else.

Top module: `pm_suspend_seq`

## Requirements
- R1: While reset is asserted, turnOffSend, pmProceed, portTimeout and wakeReq are all zero.
- R2: A suspWr pulse while idle latches suspType and starts a sequence. No turn-off is issued until wrCplSent is seen; each cycle spent waiting for it keeps turnOffSend at zero.
- R3: In the cycle after wrCplSent, turnOffSend pulses for exactly one cycle. Bit i is set when portEnable[i] and linkUp[i] are both 1, and is clear otherwise.
- R4: A live port becomes ready only when enterL23Req arrives in a cycle after its turnOffAck was seen. An enterL23Req that comes before the acknowledge, or in the same cycle as it, is ignored.
- R5: A port with portEnable or linkUp at 0 counts as ready and never receives a turn-off.
- R6: pmProceed rises in the cycle after every port is ready. proceedType then shows the latched suspType (0 = S3, 1 = S4, 2 = S5). pmProceed stays high until pmEntryAck, and the cycle after that the sequencer is idle with pmProceed low.
- R7: If the ports are not all ready TIMEOUT_CYC cycles after waiting begins, portTimeout flags each live port that is not yet ready. pmProceed then stays low even if those ports complete later, until swAbort returns the sequencer to idle. The flags clear at the end of the next turn-off pulse.
- R8: A rising edge of wakeIn gives a one-cycle wakeReq in the next cycle and returns the sequencer to idle from any state. A wakeIn held high gives no further pulse, and no other output records the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| suspWr | input | 1 | Software suspend request write strobe |
| suspType | input | 2 | Requested sleep depth: 0 = S3, 1 = S4, 2 = S5 |
| wrCplSent | input | 1 | Completion for the suspend write has been returned |
| portEnable | input | NUM_PORTS | Port enabled |
| linkUp | input | NUM_PORTS | Port has an active link |
| turnOffAck | input | NUM_PORTS | Turn-off acknowledge received, one strobe per port |
| enterL23Req | input | NUM_PORTS | Request to enter the ready-for-power-removal state, per port |
| swAbort | input | 1 | Software abort of a pending sequence |
| pmEntryAck | input | 1 | Power controller has taken the proceed request |
| wakeIn | input | 1 | Resume-well wake input, active high |
| turnOffSend | output | NUM_PORTS | One-cycle command to emit a turn-off message |
| pmProceed | output | 1 | All ports ready; power controller may enter sleep |
| proceedType | output | 2 | Sleep depth that goes with pmProceed |
| portTimeout | output | NUM_PORTS | Ports that missed the ready deadline |
| wakeReq | output | 1 | One-cycle wake request to the power controller |

## Verification
The main path is run with random live-port masks and random per-cycle acknowledge and ready strobes. Ready requests often land before or together with the acknowledge, so the point where pmProceed rises separates correct ordering from a design that takes either strobe alone. Directed runs add a mask with no live ports, which shows that dead ports count as ready and get no turn-off. A late completion shows that the turn-off waits for it. A port that stays silent until the deadline shows that the flag picks out just that port and that proceed stays blocked until abort. Wake edges during waiting, during proceed and while idle show that the pulse is single and that the sequencer drops back to idle.

// File: rtl/pm_suspend_pkg.sv
`timescale 1ns/1ps
package pm_suspend_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CPL,
    ST_SEND,
    ST_WAIT_READY,
    ST_PROCEED
  } seqState_e;

  // Strobes from control to the per-port datapath
  typedef struct packed {
    logic clearTrack; // start of a sequence: issue turn-off, reset tracking
    logic track;      // accept handshake strobes, run the deadline counter
  } trackCtl_t;

endpackage

// File: rtl/pm_suspend_ctrl.sv
`timescale 1ns/1ps
module pm_suspend_ctrl
  import pm_suspend_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       suspWr,
  input  logic [1:0] suspType,
  input  logic       wrCplSent,
  input  logic       swAbort,
  input  logic       pmEntryAck,
  input  logic       wakeIn,
  input  logic       allReady,
  input  logic       timedOut,
  output trackCtl_t  ctl,
  output logic       pmProceed,
  output logic [1:0] proceedType,
  output logic       wakeReq
);

  seqState_e state, stateNxt;
  logic      wakePrev;
  logic      wakeRise;

  assign wakeRise = wakeIn & ~wakePrev;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:       if (suspWr) stateNxt = ST_WAIT_CPL;
      ST_WAIT_CPL:   if (swAbort) stateNxt = ST_IDLE;
                     else if (wrCplSent) stateNxt = ST_SEND;
      ST_SEND:       stateNxt = ST_WAIT_READY;
      ST_WAIT_READY: if (swAbort) stateNxt = ST_IDLE;
                     else if (allReady && !timedOut) stateNxt = ST_PROCEED;
      ST_PROCEED:    if (pmEntryAck) stateNxt = ST_IDLE;
      default:       stateNxt = ST_IDLE;
    endcase
    if (wakeRise) stateNxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wakePrev    <= 1'b0;
      wakeReq     <= 1'b0;
      proceedType <= 2'd0;
    end else begin
      state    <= stateNxt;
      wakePrev <= wakeIn;
      wakeReq  <= wakeRise;
      if (state == ST_IDLE && suspWr) proceedType <= suspType;
    end
  end

  always_comb begin
    ctl.clearTrack = (state == ST_SEND);
    ctl.track      = (state == ST_WAIT_READY) && !wakeRise && !swAbort;
  end

  assign pmProceed = (state == ST_PROCEED);

endmodule

// File: rtl/pm_suspend_dp.sv
`timescale 1ns/1ps
module pm_suspend_dp
  import pm_suspend_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trackCtl_t            ctl,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] linkUp,
  input  logic [NUM_PORTS-1:0] turnOffAck,
  input  logic [NUM_PORTS-1:0] enterL23Req,
  output logic [NUM_PORTS-1:0] turnOffSend,
  output logic [NUM_PORTS-1:0] portTimeout,
  output logic                 allReady,
  output logic                 timedOut
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);

  logic [NUM_PORTS-1:0] livePort;
  logic [NUM_PORTS-1:0] portDone;
  logic [CNT_W-1:0]     waitCnt;
  logic                 expire;

  assign livePort = portEnable & linkUp;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic ackSeenQ;
    logic readyQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ackSeenQ <= 1'b0;
        readyQ   <= 1'b0;
      end else if (ctl.clearTrack) begin
        ackSeenQ <= 1'b0;
        readyQ   <= 1'b0;
      end else if (ctl.track) begin
        if (turnOffAck[i]) ackSeenQ <= 1'b1;
        // ready request only counts once the acknowledge is already on record
        if (enterL23Req[i] && ackSeenQ) readyQ <= 1'b1;
      end
    end

    assign portDone[i]    = readyQ | ~livePort[i];
    assign turnOffSend[i] = ctl.clearTrack & livePort[i];
  end

  assign allReady = &portDone;
  assign expire   = ctl.track && (waitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt     <= '0;
      portTimeout <= '0;
    end else if (ctl.clearTrack) begin
      waitCnt     <= '0;
      portTimeout <= '0;
    end else begin
      if (ctl.track && waitCnt != CNT_SAT) waitCnt <= waitCnt + CNT_W'(1);
      if (expire) portTimeout <= ~portDone;
    end
  end

  assign timedOut = |portTimeout;

endmodule

// File: rtl/pm_suspend_seq.sv
`timescale 1ns/1ps
module pm_suspend_seq
  import pm_suspend_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 suspWr,
  input  logic [1:0]           suspType,
  input  logic                 wrCplSent,
  input  logic [NUM_PORTS-1:0] portEnable,
  input  logic [NUM_PORTS-1:0] linkUp,
  input  logic [NUM_PORTS-1:0] turnOffAck,
  input  logic [NUM_PORTS-1:0] enterL23Req,
  input  logic                 swAbort,
  input  logic                 pmEntryAck,
  input  logic                 wakeIn,
  output logic [NUM_PORTS-1:0] turnOffSend,
  output logic                 pmProceed,
  output logic [1:0]           proceedType,
  output logic [NUM_PORTS-1:0] portTimeout,
  output logic                 wakeReq
);

  trackCtl_t ctl;
  logic      allReady;
  logic      timedOut;

  pm_suspend_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .suspWr      (suspWr),
    .suspType    (suspType),
    .wrCplSent   (wrCplSent),
    .swAbort     (swAbort),
    .pmEntryAck  (pmEntryAck),
    .wakeIn      (wakeIn),
    .allReady    (allReady),
    .timedOut    (timedOut),
    .ctl         (ctl),
    .pmProceed   (pmProceed),
    .proceedType (proceedType),
    .wakeReq     (wakeReq)
  );

  pm_suspend_dp #(
    .NUM_PORTS   (NUM_PORTS),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .portEnable  (portEnable),
    .linkUp      (linkUp),
    .turnOffAck  (turnOffAck),
    .enterL23Req (enterL23Req),
    .turnOffSend (turnOffSend),
    .portTimeout (portTimeout),
    .allReady    (allReady),
    .timedOut    (timedOut)
  );

endmodule

// File: rtl/pm_suspend_seq_chk.sv
`timescale 1ns/1ps
module pm_suspend_seq_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrCplSent,
  input logic [NUM_PORTS-1:0] portEnable,
  input logic [NUM_PORTS-1:0] linkUp,
  input logic                 pmEntryAck,
  input logic                 wakeIn,
  input logic [NUM_PORTS-1:0] turnOffSend,
  input logic                 pmProceed,
  input logic [NUM_PORTS-1:0] portTimeout,
  input logic                 wakeReq
);

  // turn-off only follows a returned completion
  assert_turnoff_after_cpl_R2: assert property (@(posedge clk) disable iff (!rstN)
    (turnOffSend != '0) |-> $past(wrCplSent));

  assert_turnoff_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (turnOffSend != '0) |=> (turnOffSend == '0));

  // dead ports never get a turn-off
  assert_turnoff_live_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (turnOffSend & ~(portEnable & linkUp)) == '0);

  assert_proceed_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pmProceed && !pmEntryAck && !(wakeIn && !$past(wakeIn))) |=> pmProceed);

  assert_no_proceed_timeout_R7: assert property (@(posedge clk) disable iff (!rstN)
    (portTimeout != '0) |-> !pmProceed);

  assert_wake_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (!pmProceed && turnOffSend == '0));

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);

endmodule

bind pm_suspend_seq pm_suspend_seq_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrCplSent   (wrCplSent),
  .portEnable  (portEnable),
  .linkUp      (linkUp),
  .pmEntryAck  (pmEntryAck),
  .wakeIn      (wakeIn),
  .turnOffSend (turnOffSend),
  .pmProceed   (pmProceed),
  .portTimeout (portTimeout),
  .wakeReq     (wakeReq)
);

// File: tb/pm_suspend_seq_bench.sv
`timescale 1ns/1ps
module pm_suspend_seq_bench;

  localparam int NP = 4;
  localparam int TO = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          suspWr = 1'b0;
  logic [1:0]    suspType = 2'd0;
  logic          wrCplSent = 1'b0;
  logic [NP-1:0] portEnable = '0;
  logic [NP-1:0] linkUp = '0;
  logic [NP-1:0] turnOffAck = '0;
  logic [NP-1:0] enterL23Req = '0;
  logic          swAbort = 1'b0;
  logic          pmEntryAck = 1'b0;
  logic          wakeIn = 1'b0;
  logic [NP-1:0] turnOffSend;
  logic          pmProceed;
  logic [1:0]    proceedType;
  logic [NP-1:0] portTimeout;
  logic          wakeReq;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pm_suspend_seq #(.NUM_PORTS(NP), .TIMEOUT_CYC(TO)) u_pm_suspend_seq (
    .clk(clk), .rstN(rstN), .suspWr(suspWr), .suspType(suspType),
    .wrCplSent(wrCplSent), .portEnable(portEnable), .linkUp(linkUp),
    .turnOffAck(turnOffAck), .enterL23Req(enterL23Req), .swAbort(swAbort),
    .pmEntryAck(pmEntryAck), .wakeIn(wakeIn), .turnOffSend(turnOffSend),
    .pmProceed(pmProceed), .proceedType(proceedType),
    .portTimeout(portTimeout), .wakeReq(wakeReq)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] liveMask(logic [NP-1:0] en, logic [NP-1:0] lk);
    return en & lk;
  endfunction

  function automatic logic [NP-1:0] rndMask(int den);
    logic [NP-1:0] m;
    for (int i = 0; i < NP; i++) m[i] = ($urandom_range(den - 1) == 0);
    return m;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Request, wait for completion, check turn-off; returns in the first waiting cycle
  task automatic startSuspend(logic [1:0] t, int cplDelay);
    logic [NP-1:0] live;
    live = liveMask(portEnable, linkUp);
    suspWr = 1'b1; suspType = t;
    step();
    suspWr = 1'b0;
    for (int d = 0; d < cplDelay; d++) begin
      @(negedge clk);
      check("R2 no turn-off before completion", 32'(turnOffSend), 32'd0);
      step();
    end
    wrCplSent = 1'b1;
    step();
    wrCplSent = 1'b0;
    @(negedge clk);
    check("R3 turn-off to live ports", 32'(turnOffSend), 32'(live));
    step();
    @(negedge clk);
    check("R3 turn-off lasts one cycle", 32'(turnOffSend), 32'd0);
    check("R7 flags cleared after turn-off", 32'(portTimeout), 32'd0);
  endtask

  // Random handshake strobes against a bench model of port readiness
  task automatic runWait(output bit tmo);
    logic [NP-1:0] live, ackE, rdyE, a, l, expFlags;
    bit done, allE;
    int k;
    live = liveMask(portEnable, linkUp);
    ackE = '0; rdyE = '0; k = 0; done = 1'b0; tmo = 1'b0; expFlags = '0;
    while (!done && !tmo) begin
      allE = &(rdyE | ~live);
      a = rndMask(3);
      l = rndMask(2);
      if (allE) begin a = '0; l = '0; end
      turnOffAck = a; enterL23Req = l;
      step();
      turnOffAck = '0; enterL23Req = '0;
      if (allE) done = 1'b1;
      else if (k == TO - 1) begin tmo = 1'b1; expFlags = ~(rdyE | ~live); end
      for (int i = 0; i < NP; i++) begin
        if (ackE[i] && l[i]) rdyE[i] = 1'b1;
        if (a[i]) ackE[i] = 1'b1;
      end
      k++;
      @(negedge clk);
      check("R4 R5 R6 proceed timing", 32'(pmProceed), 32'(done));
    end
    if (tmo) check("R7 timeout flags", 32'(portTimeout), 32'(expFlags));
  endtask

  task automatic finishProceed(logic [1:0] t);
    int hold;
    check("R6 proceed type", 32'(proceedType), 32'(t));
    hold = $urandom_range(3);
    for (int h = 0; h < hold; h++) begin
      step();
      @(negedge clk);
      check("R6 proceed held", 32'(pmProceed), 32'd1);
    end
    step();
    pmEntryAck = 1'b1;
    step();
    pmEntryAck = 1'b0;
    @(negedge clk);
    check("R6 idle after entry ack", 32'(pmProceed), 32'd0);
  endtask

  task automatic abortSeq();
    step();
    swAbort = 1'b1;
    step();
    swAbort = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    bit tmo;
    logic [1:0] t;
    void'($urandom(32'h5EED_0042));

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 turnOffSend in reset", 32'(turnOffSend), 32'd0);
    check("R1 pmProceed in reset", 32'(pmProceed), 32'd0);
    check("R1 portTimeout in reset", 32'(portTimeout), 32'd0);
    check("R1 wakeReq in reset", 32'(wakeReq), 32'd0);
    rstN = 1'b1;
    step();

    // R2 late completion, all ports live
    portEnable = '1; linkUp = '1;
    startSuspend(2'd1, 8);
    runWait(tmo);
    if (tmo) abortSeq(); else finishProceed(2'd1);

    // R5 no live ports: proceed immediately, no turn-off
    portEnable = '0; linkUp = '1;
    startSuspend(2'd2, 0);
    runWait(tmo);
    if (tmo) abortSeq(); else finishProceed(2'd2);

    // R4 ready request before and with the acknowledge is ignored
    portEnable = 4'b0001; linkUp = '1;
    startSuspend(2'd0, 1);
    step();
    enterL23Req = 4'b0001; step(); enterL23Req = '0;
    turnOffAck = 4'b0001; enterL23Req = 4'b0001; step();
    turnOffAck = '0; enterL23Req = '0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R4 early ready request ignored", 32'(pmProceed), 32'd0);
      step();
    end
    enterL23Req = 4'b0001; step(); enterL23Req = '0;
    @(negedge clk);
    check("R4 not yet proceeding", 32'(pmProceed), 32'd0);
    step();
    @(negedge clk);
    check("R4 proceed after ordered handshake", 32'(pmProceed), 32'd1);
    finishProceed(2'd0);

    // R7 one silent port
    portEnable = '1; linkUp = '1;
    startSuspend(2'd0, 0);
    turnOffAck = 4'b1110; step(); turnOffAck = '0;
    enterL23Req = 4'b1110; step(); enterL23Req = '0;
    repeat (TO - 3) step();
    @(negedge clk);
    check("R7 no flag before deadline", 32'(portTimeout), 32'd0);
    step();
    @(negedge clk);
    check("R7 silent port flagged", 32'(portTimeout), 32'b0001);
    turnOffAck = 4'b0001; step(); turnOffAck = '0;
    enterL23Req = 4'b0001; step(); enterL23Req = '0;
    repeat (3) step();
    @(negedge clk);
    check("R7 no proceed after timeout", 32'(pmProceed), 32'd0);
    check("R7 flag kept", 32'(portTimeout), 32'b0001);
    abortSeq();
    startSuspend(2'd1, 0);
    runWait(tmo);
    if (tmo) abortSeq(); else finishProceed(2'd1);

    // R8 wake while waiting
    startSuspend(2'd2, 0);
    step();
    wakeIn = 1'b1;
    step();
    @(negedge clk);
    check("R8 wake pulse", 32'(wakeReq), 32'd1);
    step();
    @(negedge clk);
    check("R8 single wake pulse", 32'(wakeReq), 32'd0);
    turnOffAck = '1; step(); turnOffAck = '0;
    enterL23Req = '1; step(); enterL23Req = '0;
    repeat (3) step();
    @(negedge clk);
    check("R8 idle after wake", 32'(pmProceed), 32'd0);
    check("R8 wake not recorded", 32'(portTimeout), 32'd0);
    wakeIn = 1'b0;
    step();

    // R8 wake during proceed
    portEnable = 4'b0110;
    startSuspend(2'd0, 0);
    runWait(tmo);
    if (tmo) abortSeq();
    else begin
      step();
      wakeIn = 1'b1;
      step();
      @(negedge clk);
      check("R8 wake drops proceed", 32'(pmProceed), 32'd0);
      check("R8 wake pulse in proceed", 32'(wakeReq), 32'd1);
      step();
      wakeIn = 1'b0;
    end

    // R8 wake while idle
    step();
    wakeIn = 1'b1;
    step();
    @(negedge clk);
    check("R8 wake pulse while idle", 32'(wakeReq), 32'd1);
    step();
    wakeIn = 1'b0;

    // random rounds
    for (int r = 0; r < 24; r++) begin
      portEnable = NP'($urandom) | rndMask(2);
      linkUp = NP'($urandom) | rndMask(2);
      t = 2'($urandom_range(2));
      startSuspend(t, $urandom_range(5));
      runWait(tmo);
      if (tmo) abortSeq(); else finishProceed(t);
      step();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule